// File: doc/BRIEF.md
# Software-Pipelined Vector Adder with One Memory Port

This block runs the loop `a[i] = b[i] + c[i]` for `i = 0 .. N-1` entirely in hardware. All three arrays sit in one single-port synchronous memory, so each iteration needs three accesses: two reads and one write. No value is carried from one iteration to the next, so the number of accesses alone sets the shortest possible initiation interval. That interval is three cycles, and the block starts a new iteration every third cycle.

Each iteration lasts six cycles and is split into two stages of three cycles. A fixed reservation of the three memory slots lets two iterations overlap. Slot 0 reads `b`, slot 1 reads `c`, and slot 2 writes `a`. During the prologue only the first stage is busy. During the kernel both stages run at once. During the epilogue the last iteration drains and then `done` pulses.

A caller presents the iteration count and three base addresses together with a one-cycle `start`. The block latches them and takes no further input until it has finished.

Top module: `mvadd_pipe`

## Requirements
- R1: After a `start` with N > 0, the first access happens in the cycle after `start`. Counting that cycle as offset k = 0, with interval j = k div 3 and phase k mod 3: phase 0 reads `b[j]` and phase 1 reads `c[j]` while j < N, and phase 2 writes `a[j-1]` while 1 <= j <= N. No other access is made.
- R2: Read data is taken two cycles after the read is issued. The value written to `a[i]` is `b[i] + c[i]` truncated to DW bits.
- R3: `done` is high for exactly one cycle, at offset 3N+3. That is the cycle after the last write.
- R4: With N = 0, `done` pulses in the cycle after `start` and no memory access is made.
- R5: A `start` that arrives while a run is in progress is ignored. This includes any new count or base addresses presented with it.
- R6: No access is made while the block is idle, and no memory word outside `a[0..N-1]` is ever written.
- R7: While reset is held, `done`, `mem_en` and `mem_we` are low.
- R8: The element address is the base plus the index, taken modulo 2^AW. An array may therefore wrap past the top of the address space.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle launch request |
| n_iter | input | NW | Iteration count N |
| base_b | input | AW | Address of b[0] |
| base_c | input | AW | Address of c[0] |
| base_a | input | AW | Address of a[0] |
| done | output | 1 | One-cycle completion pulse |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 1 | Write when high, read when low |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data, valid two cycles after the read |

## Verification
Every access is due at a fixed offset from the cycle after `start`. The bench samples the port at each falling edge, k = 0 up to 3N+6, and compares what it sees with the slot schedule in R1 rebuilt from N and the bases. `done` must first appear at offset 3N+3 (offset 0 when N = 0) and appear exactly once in that window. The stored results are checked only after the run has finished, by sweeping the whole memory against a snapshot taken before the run. This catches both wrong sums and writes that land anywhere other than `a`.

// File: rtl/mvadd_pkg.sv
package mvadd_pkg;
  localparam int unsigned II = 3;

  typedef enum logic [1:0] {
    SLOT_LDB = 2'd0,
    SLOT_LDC = 2'd1,
    SLOT_ST  = 2'd2
  } slot_e;

  function automatic slot_e slot_next(input slot_e s);
    case (s)
      SLOT_LDB: return SLOT_LDC;
      SLOT_LDC: return SLOT_ST;
      default:  return SLOT_LDB;
    endcase
  endfunction
endpackage

// File: rtl/mvadd_sched.sv
module mvadd_sched
  import mvadd_pkg::*;
#(
  parameter int NW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [NW-1:0] n_iter,
  output slot_e         slot,
  output logic          busy,
  output logic          launch,
  output logic          s0_vld,
  output logic [NW-1:0] s0_idx,
  output logic          s1_vld,
  output logic [NW-1:0] s1_idx,
  output logic          done
);
  logic [NW-1:0] n_q;
  logic [NW-1:0] issued;
  logic          zero_req;
  logic          more_left;
  logic          shift_now;
  logic          last_store;

  assign launch     = start && !busy && (n_iter != '0);
  assign zero_req   = start && !busy && (n_iter == '0);
  assign more_left  = issued < n_q;
  assign shift_now  = busy && (slot == SLOT_ST);
  assign last_store = shift_now && s1_vld && !s0_vld;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      slot   <= SLOT_LDB;
      s0_vld <= 1'b0;
      s0_idx <= '0;
      s1_vld <= 1'b0;
      s1_idx <= '0;
      issued <= '0;
      n_q    <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (launch) begin
        busy   <= 1'b1;
        slot   <= SLOT_LDB;
        n_q    <= n_iter;
        s0_vld <= 1'b1;
        s0_idx <= '0;
        s1_vld <= 1'b0;
        issued <= {{(NW-1){1'b0}}, 1'b1};
      end else if (zero_req) begin
        done <= 1'b1;
      end else if (busy) begin
        slot <= slot_next(slot);
        if (shift_now) begin
          s1_vld <= s0_vld;
          s1_idx <= s0_idx;
          s0_vld <= more_left;
          s0_idx <= issued;
          if (more_left) issued <= issued + 1'b1;
        end
        if (last_store) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  // R3
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R1
  stage_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s0_vld && s1_vld) |-> (s0_idx == s1_idx + 1'b1));

  // R1
  slot_rot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && slot == SLOT_LDB) |=> (slot == SLOT_LDC));

  // R4
  zero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && n_iter == '0) |=> (done && !busy));

  // R5
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !(slot == SLOT_ST && s1_vld && !s0_vld)) |=> busy);
endmodule

// File: rtl/mvadd_datapath.sv
module mvadd_datapath
  import mvadd_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  slot_e         slot,
  input  logic          busy,
  input  logic          s0_vld,
  input  logic          s1_vld,
  input  logic [DW-1:0] rdata,
  output logic [DW-1:0] sum
);
  logic [DW-1:0] b_hold;
  logic          take_b;
  logic          take_c;

  function automatic logic [DW-1:0] add_wrap(input logic [DW-1:0] x,
                                             input logic [DW-1:0] y);
    return x + y;
  endfunction

  // b[i] was read in slot 0 and arrives two cycles later, in slot 2 of stage 0.
  assign take_b = busy && s0_vld && (slot == SLOT_ST);
  // c[i] was read in slot 1 and arrives in slot 0 of stage 1.
  assign take_c = busy && s1_vld && (slot == SLOT_LDB);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      b_hold <= '0;
      sum    <= '0;
    end else begin
      if (take_b) b_hold <= rdata;
      if (take_c) sum <= add_wrap(b_hold, rdata);
    end
  end

  // R2
  sum_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && slot == SLOT_ST) |-> $stable(sum));
endmodule

// File: rtl/mvadd_portmux.sv
module mvadd_portmux
  import mvadd_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 16,
  parameter int NW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  slot_e         slot,
  input  logic          busy,
  input  logic          s0_vld,
  input  logic [NW-1:0] s0_idx,
  input  logic          s1_vld,
  input  logic [NW-1:0] s1_idx,
  input  logic [AW-1:0] bb,
  input  logic [AW-1:0] cb,
  input  logic [AW-1:0] ab,
  input  logic [DW-1:0] sum,
  output logic          mem_en,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata
);
  function automatic logic [AW-1:0] elem_addr(input logic [AW-1:0] base,
                                              input logic [NW-1:0] idx);
    return base + AW'(idx);
  endfunction

  always_comb begin
    mem_en    = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    if (busy) begin
      case (slot)
        SLOT_LDB: begin
          mem_en   = s0_vld;
          mem_addr = elem_addr(bb, s0_idx);
        end
        SLOT_LDC: begin
          mem_en   = s0_vld;
          mem_addr = elem_addr(cb, s0_idx);
        end
        default: begin
          mem_en    = s1_vld;
          mem_we    = s1_vld;
          mem_addr  = elem_addr(ab, s1_idx);
          mem_wdata = sum;
        end
      endcase
    end
  end

  // R1
  store_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_en && slot == SLOT_ST));
endmodule

// File: rtl/mvadd_pipe.sv
module mvadd_pipe
  import mvadd_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 16,
  parameter int NW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [NW-1:0] n_iter,
  input  logic [AW-1:0] base_b,
  input  logic [AW-1:0] base_c,
  input  logic [AW-1:0] base_a,
  output logic          done,
  output logic          mem_en,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata
);
  slot_e         slot;
  logic          busy;
  logic          launch;
  logic          s0_vld;
  logic          s1_vld;
  logic [NW-1:0] s0_idx;
  logic [NW-1:0] s1_idx;
  logic [DW-1:0] sum;
  logic [AW-1:0] bb_q;
  logic [AW-1:0] cb_q;
  logic [AW-1:0] ab_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bb_q <= '0;
      cb_q <= '0;
      ab_q <= '0;
    end else if (launch) begin
      bb_q <= base_b;
      cb_q <= base_c;
      ab_q <= base_a;
    end
  end

  mvadd_sched #(.NW(NW)) u_sched (
    .clk(clk), .rst_n(rst_n), .start(start), .n_iter(n_iter),
    .slot(slot), .busy(busy), .launch(launch),
    .s0_vld(s0_vld), .s0_idx(s0_idx), .s1_vld(s1_vld), .s1_idx(s1_idx),
    .done(done)
  );

  mvadd_datapath #(.DW(DW)) u_dp (
    .clk(clk), .rst_n(rst_n), .slot(slot), .busy(busy),
    .s0_vld(s0_vld), .s1_vld(s1_vld), .rdata(mem_rdata), .sum(sum)
  );

  mvadd_portmux #(.AW(AW), .DW(DW), .NW(NW)) u_mux (
    .clk(clk), .rst_n(rst_n), .slot(slot), .busy(busy),
    .s0_vld(s0_vld), .s0_idx(s0_idx), .s1_vld(s1_vld), .s1_idx(s1_idx),
    .bb(bb_q), .cb(cb_q), .ab(ab_q), .sum(sum),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata)
  );

  // R6
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_en);

  // R7
  always_comb begin
    if (!rst_n && $realtime > 0) begin
      reset_quiet_chk: assert (!mem_we || busy);
    end
  end
endmodule

// File: tb/mvadd_pipe_test.sv
`timescale 1ns/1ps
module mvadd_pipe_test;
  localparam int AW = 8;
  localparam int DW = 16;
  localparam int NW = 8;
  localparam int MW = 1 << AW;
  localparam int NV = 6;

  // {n, base_b, base_c, base_a, seed}
  localparam logic [39:0] VEC [NV] = '{
    {8'd1,  8'h10, 8'h20, 8'h30, 8'd1},
    {8'd2,  8'h10, 8'h20, 8'h30, 8'd2},
    {8'd5,  8'h40, 8'h08, 8'hA0, 8'd3},
    {8'd16, 8'h00, 8'h20, 8'h40, 8'd4},
    {8'd12, 8'h10, 8'hF8, 8'h40, 8'd5},
    {8'd40, 8'h00, 8'h30, 8'h60, 8'd6}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [NW-1:0] n_iter = '0;
  logic [AW-1:0] base_b = '0, base_c = '0, base_a = '0;
  logic          done, mem_en, mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic [DW-1:0] mem_rdata = '0;
  logic [DW-1:0] rd1 = '0;
  logic [DW-1:0] mem_m [MW];
  logic [DW-1:0] snap  [MW];

  int tests = 0;
  int fails = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  mvadd_pipe #(.AW(AW), .DW(DW), .NW(NW)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .n_iter(n_iter),
    .base_b(base_b), .base_c(base_c), .base_a(base_a), .done(done),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  // Two-cycle read memory model
  always @(posedge clk) begin
    if (mem_en && mem_we) mem_m[mem_addr] <= mem_wdata;
    rd1       <= mem_m[mem_addr];
    mem_rdata <= rd1;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 100000) begin
      tests = tests + 1;
      fails = fails + 1;
      $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cyc);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests = tests + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Expected port state at offset k: {en, we, addr}
  function automatic logic [AW+1:0] exp_port(input int k, input int n,
      input int bb, input int cb, input int ab);
    int j, ph;
    j  = k / 3;
    ph = k % 3;
    if (ph == 0 && j < n) return {1'b1, 1'b0, AW'(bb + j)};
    if (ph == 1 && j < n) return {1'b1, 1'b0, AW'(cb + j)};
    if (ph == 2 && j >= 1 && j <= n) return {1'b1, 1'b1, AW'(ab + j - 1)};
    return '0;
  endfunction

  task automatic run(input int n, input int bb, input int cb, input int ab,
                     input int seed, input bit poke);
    int lat, bad, done_at, done_cnt, mbad;
    logic [AW+1:0] got, want;
    for (int x = 0; x < MW; x++) begin
      mem_m[x] = DW'(x * 37 + seed * 11 + 5);
      snap[x]  = DW'(x * 37 + seed * 11 + 5);
    end
    @(negedge clk);
    n_iter = NW'(n); base_b = AW'(bb); base_c = AW'(cb); base_a = AW'(ab);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = (n == 0) ? 0 : 3 * n + 3;
    bad = 0; done_at = -1; done_cnt = 0;
    for (int k = 0; k <= lat + 3; k++) begin
      if (poke && k == 4) begin
        start = 1'b1; n_iter = 8'd3; base_a = 8'hF0; base_b = 8'hE0;
      end else begin
        start = 1'b0;
      end
      got  = {mem_en, mem_en & mem_we, mem_en ? mem_addr : '0};
      want = exp_port(k, n, bb, cb, ab);
      if (got !== want) bad++;
      if (done === 1'b1) begin
        done_cnt++;
        if (done_at < 0) done_at = k;
      end
      @(negedge clk);
    end
    start = 1'b0;
    // R1 slot schedule, R8 wrapped addresses, R5 start while running
    chk(bad == 0, poke ? "R5 schedule with start during run" : "R1/R8 access schedule", bad, 0);
    // R3 completion timing (R4 when n = 0)
    chk(done_at == lat, (n == 0) ? "R4 done offset" : "R3 done offset", done_at, lat);
    chk(done_cnt == 1, "R3 done pulse count", done_cnt, 1);
    mbad = 0;
    for (int x = 0; x < MW; x++) begin
      int idx;
      logic [DW-1:0] e;
      idx = (x - ab + MW) % MW;
      if (idx < n) e = snap[(bb + idx) % MW] + snap[(cb + idx) % MW];
      else e = snap[x];
      if (mem_m[x] !== e) mbad++;
    end
    // R2 sums, R6 no stray writes
    chk(mbad == 0, "R2/R6 memory contents", mbad, 0);
  endtask

  initial begin
    int quiet;
    for (int x = 0; x < MW; x++) mem_m[x] = '0;
    repeat (3) @(negedge clk);
    // R7 reset state
    chk(done === 1'b0, "R7 done in reset", int'(done), 0);
    chk(mem_en === 1'b0 && mem_we === 1'b0, "R7 port in reset", int'(mem_en), 0);
    rst_n = 1'b1;
    quiet = 0;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      if (mem_en !== 1'b0 || done !== 1'b0) quiet++;
    end
    // R6 idle block stays quiet
    chk(quiet == 0, "R6 idle port", quiet, 0);

    for (int v = 0; v < NV; v++) begin
      run(int'(VEC[v][39:32]), int'(VEC[v][31:24]), int'(VEC[v][23:16]),
          int'(VEC[v][15:8]), int'(VEC[v][7:0]), 1'b0);
    end

    // R4 zero-length run
    run(0, 8'h10, 8'h20, 8'h30, 9, 1'b0);
    // R5 start while busy is ignored
    run(6, 8'h10, 8'h20, 8'h30, 10, 1'b1);
    // back-to-back start after finishing
    run(3, 8'h50, 8'h60, 8'h70, 11, 1'b0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule